// File: doc/BRIEF.md
# Boot Fetch Address Bit-Flip Remapper

This block sits in the address path between a processor and an 8-bit boot flash that fills the upper 2 MB of a 32-bit address space (0xFFE0_0000 to 0xFFFF_FFFF). The processor's hard-reset fetch lands at 0xFFF0_0100, which is near the middle of that flash. If nothing changes that address, the boot image must be split around it. To avoid the split, the block inverts address bit 20 for the first two memory accesses after reset. The reset fetch therefore reaches 0xFFE0_0100, the flash base plus the vector offset, and the boot code can sit contiguously from the bottom of the device.

The block counts transfer-start strobes from reset. While fewer than two have been seen, bit 20 of the outgoing address is inverted. Once two have been seen, addresses pass through untouched until the next reset. Every other address bit is a straight wire. A status output tells observers that the remapping window has closed.

Top module: `boot_vector_remap`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `remap_done` is 0 and bit 20 of `addr_out` is the inverse of bit 20 of `addr_in`.
- R2: On the first strobed access after reset, an input address of 0xFFF0_0100 appears on `addr_out` as 0xFFE0_0100 in the same cycle.
- R3: The second strobed access after reset also has bit 20 inverted.
- R4: From the cycle after the second strobe onward, `addr_out` equals `addr_in` and `remap_done` is 1.
- R5: A cycle with `xfer_start` low does not advance the access count, so the inversion window survives any number of idle cycles.
- R6: Every bit of `addr_out` other than bit 20 always equals the same bit of `addr_in`, combinationally.
- R7: The inversion works in both directions: an address with bit 20 clear gets bit 20 set while the window is open.
- R8: Once set, `remap_done` stays at 1 until reset. A reset reopens the window for two more accesses.
- R9: Strobes on consecutive cycles each count, so two back-to-back strobes close the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | High for one cycle at the start of each processor memory access |
| addr_in | input | 32 | Address from the processor |
| addr_out | output | 32 | Address toward the flash, with bit 20 inverted during the window |
| remap_done | output | 1 | 1 once two accesses have been counted since reset |

## Verification
The assertions check several properties on every cycle:
- all bits other than bit 20 pass through unchanged;
- bit 20 is inverted exactly while `remap_done` is low;
- `remap_done` never drops without a reset;
- `remap_done` agrees with an independent strobe count.

Only the bench scenarios can show the concrete vector translation from 0xFFF0_0100 to 0xFFE0_0100 and the set-direction flip. The same is true for long idle gaps inside the window, back-to-back strobes, and a reset in the middle of operation that reopens the window.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

    localparam int ADDR_W         = 32;
    localparam int FLIP_BIT       = 20;
    localparam int REMAP_ACCESSES = 2;

    typedef enum logic {
        PH_REMAP = 1'b0,
        PH_PASS  = 1'b1
    } phase_e;

    function automatic logic in_window(input int unsigned seen, input int unsigned limit);
        return seen < limit;
    endfunction

endpackage

// File: rtl/remap_access_counter.sv
module remap_access_counter
    import boot_remap_pkg::*;
#(
    parameter int LIMIT = REMAP_ACCESSES
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   xfer_start,
    output phase_e phase
);
    localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             saturated;

    assign saturated = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (xfer_start && !saturated) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        phase = in_window(int'(cnt_q), LIMIT) ? PH_REMAP : PH_PASS;
    end

endmodule

// File: rtl/addr_bit_flip.sv
module addr_bit_flip #(
    parameter int W   = 32,
    parameter int BIT = 20
) (
    input  logic [W-1:0] a,
    input  logic         invert,
    output logic [W-1:0] y
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (g == BIT) begin : g_flip
            assign y[g] = a[g] ^ invert;
        end else begin : g_wire
            assign y[g] = a[g];
        end
    end

endmodule

// File: rtl/boot_vector_remap.sv
module boot_vector_remap
    import boot_remap_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int FLIP_POS  = FLIP_BIT,
    parameter int N_REMAP   = REMAP_ACCESSES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_start,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic          remap_done
);
    phase_e phase;

    remap_access_counter #(
        .LIMIT(N_REMAP)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .phase      (phase)
    );

    addr_bit_flip #(
        .W   (AW),
        .BIT (FLIP_POS)
    ) u_flip (
        .a      (addr_in),
        .invert (phase == PH_REMAP),
        .y      (addr_out)
    );

    assign remap_done = (phase == PH_PASS);

endmodule

// File: rtl/boot_vector_remap_chk.sv
module boot_vector_remap_chk #(
    parameter int AW       = 32,
    parameter int FLIP_POS = 20,
    parameter int N_REMAP  = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          xfer_start,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out,
    input logic          remap_done
);
    localparam logic [AW-1:0] FLIP_MASK = {{(AW-1){1'b0}}, 1'b1} << FLIP_POS;

    int seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 0;
        end else if (xfer_start && seen < N_REMAP) begin
            seen <= seen + 1;
        end
    end

    // R6: bits other than the flipped one never differ
    a_r6_other_bits: assert property (@(posedge clk) disable iff (rst)
        ((addr_out ^ addr_in) & ~FLIP_MASK) == '0);

    // R3 / R4: flipped bit differs exactly while the window is open
    a_r4_window_flip: assert property (@(posedge clk) disable iff (rst)
        (addr_out[FLIP_POS] != addr_in[FLIP_POS]) == !remap_done);

    // R8: done is sticky until reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        remap_done |=> remap_done);

    // R5 / R9: done tracks an independent strobe count
    a_r5_count_track: assert property (@(posedge clk) disable iff (rst)
        remap_done == (seen >= N_REMAP));

    // R1: window is open right after reset
    a_r1_reset_open: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !remap_done);

endmodule

bind boot_vector_remap boot_vector_remap_chk #(
    .AW       (AW),
    .FLIP_POS (FLIP_POS),
    .N_REMAP  (N_REMAP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .remap_done (remap_done)
);

// File: tb/tb_boot_vector_remap.sv
module tb_boot_vector_remap;

    localparam time HALF = 2.5ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_start = 1'b0;
    logic [31:0] addr_in = 32'h0;
    logic [31:0] addr_out;
    logic        remap_done;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    accesses = 0;
    bit    started  = 1'b0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    always #HALF clk = ~clk;

    boot_vector_remap dut (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .remap_done (remap_done)
    );

    // behavioural reference: count strobes since reset
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) accesses <= 0;
        else if (xfer_start) accesses <= accesses + 1;
    end

    function automatic logic [31:0] model_addr(input logic [31:0] a, input int acc);
        return (acc < 2) ? (a ^ 32'h0010_0000) : a;
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            n_checks++;
            if ((addr_out & ~32'h0010_0000) != (addr_in & ~32'h0010_0000)) begin
                n_fails++;
                $display("FAIL R6 other bits: got %h exp %h", addr_out, addr_in);
            end
            n_checks++;
            if (addr_out[20] != model_addr(addr_in, accesses)[20]) begin
                n_fails++;
                $display("FAIL %s bit20: got %b exp %b", cur_req, addr_out[20],
                         model_addr(addr_in, accesses)[20]);
            end
            n_checks++;
            if (remap_done != (accesses >= 2)) begin
                n_fails++;
                $display("FAIL %s/R8 done: got %b exp %b", cur_req, remap_done, accesses >= 2);
            end
        end
    end

    task automatic cyc(input logic s, input logic [31:0] a);
        @(posedge clk);
        #1;
        xfer_start = s;
        addr_in    = a;
    endtask

    task automatic expect_out(input logic [31:0] exp, input string tag);
        @(negedge clk);
        #0.5;
        n_checks++;
        if (addr_out !== exp) begin
            n_fails++;
            $display("FAIL %s addr: got %h exp %h", tag, addr_out, exp);
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        cyc(1'b0, 32'hFFF0_0100);
        cyc(1'b1, 32'hFFF0_0100);  // strobe during reset is ignored
        cyc(1'b0, 32'hFFF0_0100);
        expect_out(32'hFFE0_0100, "R1");
        cyc(1'b0, 32'hFFF0_0100);
        rst = 1'b0;
        expect_out(32'hFFE0_0100, "R1");

        // R5 / R7: idle cycles, address with bit 20 clear
        cur_req = "R5";
        for (int i = 0; i < 6; i++) cyc(1'b0, 32'hFFE0_0000 + 32'(i * 4));
        cyc(1'b0, 32'hFFE0_0040);
        expect_out(32'hFFF0_0040, "R7");

        // R2: first access, vector redirect
        cur_req = "R2";
        cyc(1'b1, 32'hFFF0_0100);
        expect_out(32'hFFE0_0100, "R2");

        cur_req = "R5";
        cyc(1'b0, 32'h1234_5678);
        cyc(1'b0, 32'hA5A5_5A5A);
        expect_out(32'hA5B5_5A5A, "R5");

        // R3: second access
        cur_req = "R3";
        cyc(1'b1, 32'hFFF0_0104);
        expect_out(32'hFFE0_0104, "R3");

        // R4: pass-through afterwards
        cur_req = "R4";
        cyc(1'b1, 32'hFFF0_0108);
        expect_out(32'hFFF0_0108, "R4");
        cyc(1'b0, 32'hFFE0_0200);
        expect_out(32'hFFE0_0200, "R4");
        for (int i = 0; i < 10; i++) cyc(i[0], 32'h5A5A_A5A5 ^ 32'(i << 18));
        cur_req = "R8";
        cyc(1'b1, 32'h0000_0000);
        expect_out(32'h0000_0000, "R8");

        // R8: reset mid-stream reopens window
        cyc(1'b0, 32'hFFF0_0100);
        rst = 1'b1;
        cyc(1'b0, 32'hFFF0_0100);
        cyc(1'b0, 32'hFFF0_0100);
        rst = 1'b0;
        expect_out(32'hFFE0_0100, "R8");

        // R9: back-to-back strobes
        cur_req = "R9";
        cyc(1'b1, 32'hFFF0_0100);
        expect_out(32'hFFE0_0100, "R9");
        cyc(1'b1, 32'hFFF0_0104);
        expect_out(32'hFFE0_0104, "R9");
        cyc(1'b1, 32'hFFF0_0108);
        expect_out(32'hFFF0_0108, "R9");
        cyc(1'b0, 32'h0010_0000);
        expect_out(32'h0010_0000, "R9");
        cyc(1'b0, 32'h0);

        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule